// File: doc/BRIEF.md
# Serial Port Register Block with Paced Interrupts

This block is the byte-wide register front end of a PC-style serial port. A host reaches eight registers through a 3-bit offset, one byte per access. Bit 7 of the line control register switches offsets 0 and 1 between the data and interrupt-enable registers and the two divisor bytes. Received bytes arrive on a valid/ready byte stream. Each byte written to the data register leaves through a one-cycle strobe. Reads are combinational from the current state, and their side effects take place at the clock edge that ends the access.

Receive and transmit interrupts are paced. Each source has its own countdown of `PACE_CYCLES` cycles. A source's status bit is set, and the level interrupt output raised, only when its countdown expires while its enable bit is still set. There is one exception. Enabling the transmit interrupt posts it at once if the last transmit interrupt is older than the pacing delay.

Top module: `serial_regfile`

## Requirements
- R1: After reset, the interrupt enable register (offset 1) and the line control register (offset 3) read 0x00, the identification register (offset 2) reads 0x01, the line status register (offset 5) reads 0x60 with no byte offered, and `irq` is low.
- R2: With bit 7 of the line control register set, offsets 0 and 1 read and write two divisor bytes. A write to offset 0 then produces no transmit strobe, and the interrupt enable register keeps its value.
- R3: With bit 7 clear, a read of offset 0 returns the offered receive byte, or 0x00 when `rx_valid` is low, and asserts `rx_ready` during that access. A write of offset 0 pulses `tx_strobe` for one cycle with the written byte on `tx_data`.
- R4: The identification register reads 0x04 while receive status is pending, 0x02 while only transmit status is pending, and 0x01 when neither is pending.
- R5: A read of the identification register that returns 0x02 clears the transmit status, so the next read returns 0x01.
- R6: The line status register reads 0x60 with bit 0 (data ready) equal to `rx_valid`.
- R7: Offsets 6 and 7 read 0x00. Writes to offsets 2 and 7 change no register state.
- R8: A write of offset 0 while the transmit enable (interrupt enable bit 1) is set schedules a transmit interrupt. Its status and `irq` appear `PACE_CYCLES` clock edges after the scheduling edge, and not before.
- R9: A write of the interrupt enable register with bit 1 set posts the transmit interrupt at that edge if more than `PACE_CYCLES` cycles have passed since the last transmit post, or since reset. Otherwise it schedules the interrupt `PACE_CYCLES` edges later.
- R10: A write of the interrupt enable register with bit 1 clear cancels a scheduled transmit interrupt and lowers `irq`. With bit 0 clear, it does the same for the receive interrupt.
- R11: A read or write of the data register lowers `irq`.
- R12: Scheduling a source again while its countdown runs restarts the countdown at the full delay.
- R13: With the receive enable (interrupt enable bit 0) set, a rising `rx_valid` or a data-register read schedules a receive interrupt. At expiry it posts only if a byte is still offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational) |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Offered receive byte |
| rx_ready | output | 1 | Offered byte taken at this edge |
| tx_strobe | output | 1 | Transmit byte valid for one cycle |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt to the platform |

## Verification
A wrong countdown shows up as `irq` rising one edge early or late against the scheduling access. The bench therefore samples the output exactly one edge before and at the expected posting edge. If the transmit age tracker is wrong, the very next enable write reveals it, because `irq` either appears at once or appears only after the full delay. Wrong pending status is visible on the next identification read: a stale transmit bit returns 0x02 where 0x01 is due, and a lost clear-on-read repeats the code.

// File: rtl/serial_pkg.sv
package serial_pkg;
   localparam logic [2:0] OFS_DATA = 3'd0;
   localparam logic [2:0] OFS_IEN  = 3'd1;
   localparam logic [2:0] OFS_IDENT = 3'd2;
   localparam logic [2:0] OFS_LCTL = 3'd3;
   localparam logic [2:0] OFS_MCTL = 3'd4;
   localparam logic [2:0] OFS_LSTAT = 3'd5;

   localparam logic [7:0] ID_NONE = 8'h01;
   localparam logic [7:0] ID_TX   = 8'h02;
   localparam logic [7:0] ID_RX   = 8'h04;
   localparam logic [7:0] LSTAT_BASE = 8'h60;

   localparam int EN_RX = 0;
   localparam int EN_TX = 1;
   localparam int LCTL_DIV = 7;
   localparam int NSRC = 2;
endpackage

// File: rtl/serial_pace_timer.sv
module serial_pace_timer #(
   parameter int unsigned DELAY = 450
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic abort,
   output logic fire
);
   localparam int CW = $clog2(DELAY + 1);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (abort)  cnt_q <= '0;
      else if (arm)    cnt_q <= CW'(DELAY);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign fire = (cnt_q == CW'(1));
endmodule

// File: rtl/serial_tx_age.sv
module serial_tx_age #(
   parameter int unsigned LIMIT = 450
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mark,
   output logic expired
);
   localparam int AW = $clog2(LIMIT + 2);
   localparam logic [AW-1:0] SAT = AW'(LIMIT + 1);
   logic [AW-1:0] age_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          age_q <= SAT;
      else if (mark)       age_q <= '0;
      else if (age_q != SAT) age_q <= age_q + 1'b1;
   end

   assign expired = (age_q == SAT);
endmodule

// File: rtl/serial_regfile.sv
module serial_regfile #(
   parameter int unsigned PACE_CYCLES = 450
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_sel,
   input  logic       bus_we,
   input  logic [2:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   output logic       rx_ready,
   output logic       tx_strobe,
   output logic [7:0] tx_data,
   output logic       irq
);
   import serial_pkg::*;

   if (PACE_CYCLES < 2) begin : g_bad_pace
      $error("PACE_CYCLES must be at least 2");
   end

   logic [7:0] ien_q, lctl_q, mctl_q, div_lo_q, div_hi_q;
   logic       rx_pend_q, tx_pend_q, irq_q, rx_prev_q;
   logic [NSRC-1:0] arm, abort, fire;
   logic       age_expired, tx_now, rx_post, tx_post, irq_drop;

   wire div_sel = lctl_q[LCTL_DIV];
   wire rd_acc  = bus_sel & ~bus_we;
   wire wr_acc  = bus_sel & bus_we;
   wire data_rd = rd_acc & (bus_addr == OFS_DATA) & ~div_sel;
   wire data_wr = wr_acc & (bus_addr == OFS_DATA) & ~div_sel;
   wire ien_wr  = wr_acc & (bus_addr == OFS_IEN) & ~div_sel;
   wire id_rd   = rd_acc & (bus_addr == OFS_IDENT);
   wire rx_rise = rx_valid & ~rx_prev_q;

   assign arm[EN_RX]   = (data_rd & ien_q[EN_RX])
                       | (ien_wr & bus_wdata[EN_RX] & rx_valid)
                       | (rx_rise & ien_q[EN_RX] & ~ien_wr);
   assign abort[EN_RX] = ien_wr & ~bus_wdata[EN_RX];
   assign tx_now       = ien_wr & bus_wdata[EN_TX] & age_expired;
   assign arm[EN_TX]   = (data_wr & ien_q[EN_TX])
                       | (ien_wr & bus_wdata[EN_TX] & ~age_expired);
   assign abort[EN_TX] = ien_wr & ~bus_wdata[EN_TX];

   for (genvar g = 0; g < NSRC; g++) begin : g_pace
      serial_pace_timer #(.DELAY(PACE_CYCLES)) u_timer (
         .clk(clk), .rst_n(rst_n), .arm(arm[g]), .abort(abort[g]), .fire(fire[g])
      );
   end

   assign rx_post  = fire[EN_RX] & ien_q[EN_RX] & rx_valid & ~arm[EN_RX] & ~abort[EN_RX];
   assign tx_post  = (fire[EN_TX] & ien_q[EN_TX] & ~arm[EN_TX] & ~abort[EN_TX]) | tx_now;
   assign irq_drop = data_rd | data_wr | (ien_wr & ~(bus_wdata[EN_RX] & bus_wdata[EN_TX]));

   serial_tx_age #(.LIMIT(PACE_CYCLES)) u_age (
      .clk(clk), .rst_n(rst_n), .mark(tx_post), .expired(age_expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien_q <= '0; lctl_q <= '0; mctl_q <= '0; div_lo_q <= '0; div_hi_q <= '0;
         rx_pend_q <= 1'b0; tx_pend_q <= 1'b0; irq_q <= 1'b0; rx_prev_q <= 1'b0;
      end else begin
         rx_prev_q <= rx_valid;
         if (wr_acc) begin
            unique case (bus_addr)
               OFS_DATA: if (div_sel) div_lo_q <= bus_wdata;
               OFS_IEN:  if (div_sel) div_hi_q <= bus_wdata; else ien_q <= bus_wdata;
               OFS_LCTL: lctl_q <= bus_wdata;
               OFS_MCTL: mctl_q <= bus_wdata;
               default: ;
            endcase
         end
         if (rx_post)      rx_pend_q <= 1'b1;
         else if (data_rd) rx_pend_q <= 1'b0;
         if (tx_post)      tx_pend_q <= 1'b1;
         else if (data_wr | abort[EN_TX] | (id_rd & ~rx_pend_q)) tx_pend_q <= 1'b0;
         if (rx_post | tx_post) irq_q <= 1'b1;
         else if (irq_drop)     irq_q <= 1'b0;
      end
   end

   always_comb begin
      unique case (bus_addr)
         OFS_DATA:  bus_rdata = div_sel ? div_lo_q : (rx_valid ? rx_data : 8'h00);
         OFS_IEN:   bus_rdata = div_sel ? div_hi_q : ien_q;
         OFS_IDENT: bus_rdata = rx_pend_q ? ID_RX : (tx_pend_q ? ID_TX : ID_NONE);
         OFS_LCTL:  bus_rdata = lctl_q;
         OFS_MCTL:  bus_rdata = mctl_q;
         OFS_LSTAT: bus_rdata = LSTAT_BASE | {7'd0, rx_valid};
         default:   bus_rdata = 8'h00;
      endcase
   end

   assign rx_ready  = data_rd;
   assign tx_strobe = data_wr;
   assign tx_data   = bus_wdata;
   assign irq       = irq_q;
endmodule

// File: rtl/serial_regfile_chk.sv
module serial_regfile_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_sel,
   input logic       bus_we,
   input logic [2:0] bus_addr,
   input logic [7:0] bus_rdata,
   input logic [7:0] lctl,
   input logic [7:0] ien,
   input logic       tx_strobe,
   input logic       irq,
   input logic       tx_fire,
   input logic       tx_arm,
   input logic       tx_abort
);
   // R4
   iir_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_addr == 3'd2) |->
      (bus_rdata == 8'h01 || bus_rdata == 8'h02 || bus_rdata == 8'h04));
   // R6
   lsr_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_addr == 3'd5) |-> (bus_rdata[7:1] == 7'b0110000));
   // R7
   blank_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_addr >= 3'd6) |-> (bus_rdata == 8'h00));
   // R2
   no_tx_in_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_strobe |-> !lctl[7]);
   // R8
   tx_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_fire && ien[1] && !tx_arm && !tx_abort) |=> irq);
   // R11
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(bus_sel && (bus_addr == 3'd0 || (bus_we && bus_addr == 3'd1))));
endmodule

bind serial_regfile serial_regfile_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_rdata(bus_rdata), .lctl(lctl_q), .ien(ien_q), .tx_strobe(tx_strobe), .irq(irq),
   .tx_fire(fire[1]), .tx_arm(arm[1]), .tx_abort(abort[1])
);

// File: tb/serial_regfile_bench.sv
module serial_regfile_bench;
   localparam int unsigned D = 450;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_sel = 1'b0, bus_we = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic rx_ready, tx_strobe, irq;
   logic [7:0] tx_data;

   int compared = 0, mismatched = 0, tx_cnt = 0, cycles = 0;
   logic [7:0] tx_last = '0;
   bit done = 0;

   always #2 clk = ~clk;

   serial_regfile #(.PACE_CYCLES(D)) u_serial_regfile (.*);

   always @(posedge clk) if (tx_strobe) begin tx_cnt++; tx_last = tx_data; end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1;
         mismatched++;
         $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1; bus_sel = 0; bus_we = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic rdy);
      @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
      #1; d = bus_rdata; rdy = rx_ready;
      @(posedge clk); #1; bus_sel = 0;
      if (rdy) rx_valid = 0;
   endtask

   task automatic waitc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic t_reset;
      logic [7:0] d; logic r;
      rd(3'd1, d, r); chk("R1 ien", d, 8'h00);
      rd(3'd3, d, r); chk("R1 lctl", d, 8'h00);
      rd(3'd2, d, r); chk("R1 ident", d, 8'h01);
      rd(3'd5, d, r); chk("R1/R6 lstat", d, 8'h60);
      chk("R1 irq", irq, 1'b0);
   endtask

   task automatic t_divisor;
      logic [7:0] d; logic r; int n0;
      n0 = tx_cnt;
      wr(3'd3, 8'h80); wr(3'd0, 8'h34); wr(3'd1, 8'h12);
      rd(3'd0, d, r); chk("R2 div lo", d, 8'h34);
      rd(3'd1, d, r); chk("R2 div hi", d, 8'h12);
      chk("R2 no strobe", 8'(tx_cnt - n0), 8'd0);
      wr(3'd3, 8'h03);
      rd(3'd3, d, r); chk("R2 lctl", d, 8'h03);
      rd(3'd1, d, r); chk("R2 ien kept", d, 8'h00);
   endtask

   task automatic t_ignored;
      logic [7:0] d; logic r;
      wr(3'd7, 8'hFF); wr(3'd2, 8'hFF);
      rd(3'd6, d, r); chk("R7 ofs6", d, 8'h00);
      rd(3'd7, d, r); chk("R7 ofs7", d, 8'h00);
      rd(3'd2, d, r); chk("R7 ident", d, 8'h01);
      rd(3'd3, d, r); chk("R7 lctl", d, 8'h03);
      rd(3'd1, d, r); chk("R7 ien", d, 8'h00);
   endtask

   task automatic t_tx_immediate;
      logic [7:0] d; logic r; int n0;
      wr(3'd1, 8'h02);
      chk("R9 immediate irq", irq, 1'b1);
      rd(3'd2, d, r); chk("R4 ident tx", d, 8'h02);
      rd(3'd2, d, r); chk("R5 cleared", d, 8'h01);
      n0 = tx_cnt;
      wr(3'd0, 8'h5A);
      chk("R3 strobe", 8'(tx_cnt - n0), 8'd1);
      chk("R3 tx data", tx_last, 8'h5A);
      chk("R11 irq drop on write", irq, 1'b0);
      waitc(D - 1); chk("R8 not early", irq, 1'b0);
      waitc(1);     chk("R8 posted", irq, 1'b1);
      rd(3'd2, d, r); chk("R8 ident", d, 8'h02);
   endtask

   task automatic t_tx_recent;
      wr(3'd1, 8'h00);
      chk("R10 irq drop", irq, 1'b0);
      wr(3'd1, 8'h02);
      chk("R9 deferred", irq, 1'b0);
      waitc(D - 1); chk("R9 not early", irq, 1'b0);
      waitc(1);     chk("R9 posted", irq, 1'b1);
   endtask

   task automatic t_restart;
      wr(3'd0, 8'h11);
      waitc(9);
      wr(3'd0, 8'h22);
      waitc(D - 1); chk("R12 restarted", irq, 1'b0);
      waitc(1);     chk("R12 posted", irq, 1'b1);
   endtask

   task automatic t_cancel;
      logic [7:0] d; logic r;
      wr(3'd0, 8'h33);
      waitc(10);
      wr(3'd1, 8'h00);
      waitc(D + 20); chk("R10 cancelled", irq, 1'b0);
      rd(3'd2, d, r); chk("R10 ident", d, 8'h01);
   endtask

   task automatic t_rx;
      logic [7:0] d; logic r;
      @(negedge clk); rx_valid = 1; rx_data = 8'hA5;
      wr(3'd1, 8'h03);
      chk("R9 tx immediate", irq, 1'b1);
      waitc(D - 1);
      rd(3'd5, d, r); chk("R6 data ready", d, 8'h61);
      rd(3'd2, d, r); chk("R4 rx first", d, 8'h04);
      rd(3'd0, d, r); chk("R3 rx byte", d, 8'hA5);
      chk("R3 rx ready", r, 1'b1);
      chk("R11 irq drop on read", irq, 1'b0);
      rd(3'd2, d, r); chk("R4 tx next", d, 8'h02);
      rd(3'd2, d, r); chk("R5 none", d, 8'h01);
      rd(3'd0, d, r); chk("R3 empty read", d, 8'h00);
      waitc(D + 5); chk("R13 no byte no post", irq, 1'b0);
      @(negedge clk); rx_valid = 1; rx_data = 8'h3C;
      @(posedge clk); #1;
      waitc(D - 1); chk("R13 not early", irq, 1'b0);
      waitc(1);     chk("R13 posted", irq, 1'b1);
      rd(3'd2, d, r); chk("R13 ident", d, 8'h04);
   endtask

   initial begin
      waitc(3);
      @(negedge clk); rst_n = 1;
      t_reset();
      t_divisor();
      t_ignored();
      t_tx_immediate();
      t_tx_recent();
      t_restart();
      t_cancel();
      t_rx();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule